// File: doc/BRIEF.md
# Integer Multiply/Divide Unit

This block performs the eight standard 32-bit integer multiply and divide operations of a RISC-style core. The caller offers two operands and a 3-bit operation code on a valid/ready input channel. When the transfer is accepted, the unit latches the request and raises `busy`. Some cycles later it presents the 32-bit answer on `result` together with a single-cycle `out_valid` strobe.

A single 2W-bit product serves all four multiply flavours. Operand sign handling picks signed or unsigned extension for each operand. The operation code then selects the low or high half of the product.

Division is a restoring shift-subtract loop that works on operand magnitudes. It runs a fixed number of iterations, with one conditioning cycle before the loop and one sign-correction cycle after it. A zero divisor and signed overflow never trap. Both are resolved in the conditioning cycle and return defined values.

Back-pressure rules:
- `in_ready` is high only while the unit is idle. A request counts as taken on a clock edge where both `in_valid` and `in_ready` are high.
- `in_valid` raised while the unit is busy has no effect.
- The output channel cannot be stalled. `out_valid` is a pulse, and `result` keeps its value until the following completion.

Top module: `muldiv_unit`

## Requirements
- R1: `in_ready` is high and `busy` low exactly when the unit is idle. A request presented while busy is ignored: it neither changes the result in progress nor starts a new operation afterwards.
- R2: Code 0 (MUL) returns the low 32 bits of the product of the operands.
- R3: Codes 1, 2 and 3 return the high 32 bits of the 64-bit product. Code 1 treats both operands as signed, code 2 treats `op_a` as signed and `op_b` as unsigned, and code 3 treats both as unsigned.
- R4: Code 4 (signed DIV) and code 5 (unsigned DIVU) with a zero divisor return 0xFFFFFFFF.
- R5: Code 6 (signed REM) and code 7 (unsigned REMU) with a zero divisor return `op_a` unchanged.
- R6: Code 4 with `op_a`=0x80000000 and `op_b`=0xFFFFFFFF returns 0x80000000, and code 6 with the same operands returns 0.
- R7: For all other divisions, the signed quotient truncates toward zero and the signed remainder takes the sign of the dividend. Unsigned codes 5 and 7 give the ordinary quotient and remainder.
- R8: `out_valid` rises 1 cycle after acceptance for multiplies, for zero-divisor divisions and for signed-overflow divisions. It rises 34 cycles after acceptance for all other divisions. `busy` stays high from acceptance until that cycle.
- R9: `out_valid` lasts exactly one cycle, and `result` holds its value until the next completion.
- R10: After reset `busy` and `out_valid` are 0, `in_ready` is 1 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can take a request |
| in_func | input | 3 | Operation code 0..7 |
| in_a | input | 32 | First operand (dividend / multiplicand) |
| in_b | input | 32 | Second operand (divisor / multiplier) |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | One-cycle completion strobe |
| result | output | 32 | Answer, held until the next completion |

## Verification
Several properties are checked by assertions on every cycle:
- the completion strobe lasts one cycle and the result holds between completions;
- a multiply completes on the cycle after it starts;
- a zero divisor or signed overflow leads straight to its defined answer;
- the partial remainder inside the divider always stays below the divisor.

Other behaviour can only be shown by the bench's scenarios:
- the arithmetic values for each code across signed, unsigned and mixed-sign corner operands;
- the exact 34-cycle division latency;
- a request raised mid-division having no effect.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_PREP,
    ST_LOOP,
    ST_FIX
  } mdu_state_t;

  localparam logic [2:0] OP_MUL    = 3'd0;
  localparam logic [2:0] OP_MULH   = 3'd1;
  localparam logic [2:0] OP_MULHSU = 3'd2;
  localparam logic [2:0] OP_MULHU  = 3'd3;
  localparam logic [2:0] OP_DIV    = 3'd4;
  localparam logic [2:0] OP_DIVU   = 3'd5;
  localparam logic [2:0] OP_REM    = 3'd6;
  localparam logic [2:0] OP_REMU   = 3'd7;
endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
  parameter int W = 32
) (
  input  logic [2:0]   func,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_sel
);
  import muldiv_pkg::*;
  localparam int PW = 2 * W;

  logic         a_signed, b_signed;
  logic [PW-1:0] ext_a, ext_b, full;

  // code 1: both operands signed; code 2: only the first operand signed
  assign a_signed = (func == OP_MULH) || (func == OP_MULHSU);
  assign b_signed = (func == OP_MULH);

  // extending both operands to 2W bits makes a 2W-bit truncated product exact
  assign ext_a = {{W{a_signed & a[W-1]}}, a};
  assign ext_b = {{W{b_signed & b[W-1]}}, b};
  assign full  = ext_a * ext_b;

  assign prod_sel = (func == OP_MUL) ? full[W-1:0] : full[PW-1:W];
endmodule

// File: rtl/muldiv_divcore.sv
module muldiv_divcore #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         last
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, trial;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quot = quo_q;
  assign rem  = rem_q;
  assign last = run && (cnt_q == LAST_CNT);

  // restoring invariant: the partial remainder never reaches the divisor
  p_rem_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_func,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] result
);
  import muldiv_pkg::*;
  localparam logic [W-1:0] MIN_NEG  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = '1;

  mdu_state_t   state_q;
  logic [2:0]   func_q;
  logic [W-1:0] a_q, b_q;
  logic         neg_q_q, neg_r_q;
  logic         accept, is_signed, neg_a, neg_b, b_zero, ovf, corner;
  logic [W-1:0] mag_a, mag_b, mul_out, dq, dr, last_dummy_unused;
  logic         div_last, div_load, div_run;

  assign in_ready = (state_q == ST_IDLE);
  assign busy     = (state_q != ST_IDLE);
  assign accept   = in_valid && in_ready;

  // signed division codes are 4 and 6 (bit 0 clear)
  assign is_signed = !func_q[0];
  assign neg_a     = is_signed && a_q[W-1];
  assign neg_b     = is_signed && b_q[W-1];
  assign mag_a     = neg_a ? (~a_q + 1'b1) : a_q;
  assign mag_b     = neg_b ? (~b_q + 1'b1) : b_q;
  assign b_zero    = (b_q == '0);
  assign ovf       = is_signed && (a_q == MIN_NEG) && (b_q == ALL_ONES);
  assign corner    = b_zero || ovf;

  assign div_load  = (state_q == ST_PREP) && !corner;
  assign div_run   = (state_q == ST_LOOP);
  assign last_dummy_unused = '0;

  muldiv_mult #(.W(W)) u_mult (
    .func     (func_q),
    .a        (a_q),
    .b        (b_q),
    .prod_sel (mul_out)
  );

  muldiv_divcore #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .run      (div_run),
    .dividend (mag_a),
    .divisor  (mag_b),
    .quot     (dq),
    .rem      (dr),
    .last     (div_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      func_q    <= '0;
      a_q       <= '0;
      b_q       <= '0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          func_q  <= in_func;
          a_q     <= in_a;
          b_q     <= in_b;
          state_q <= in_func[2] ? ST_PREP : ST_MUL;
        end
        ST_MUL: begin
          result    <= mul_out;
          out_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_PREP: begin
          if (b_zero) begin
            result    <= func_q[1] ? a_q : ALL_ONES;
            out_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (ovf) begin
            result    <= func_q[1] ? '0 : MIN_NEG;
            out_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            neg_q_q <= neg_a ^ neg_b;
            neg_r_q <= neg_a;
            state_q <= ST_LOOP;
          end
        end
        ST_LOOP: if (div_last) state_q <= ST_FIX;
        ST_FIX: begin
          if (func_q[1]) result <= neg_r_q ? (~dr + 1'b1) : dr;
          else           result <= neg_q_q ? (~dq + 1'b1) : dq;
          out_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));
  p_mul_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUL) |=> (out_valid && !busy));
  p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP && b_zero && !func_q[1]) |=> (out_valid && result == ALL_ONES));
  p_rem_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP && b_zero && func_q[1]) |=> (out_valid && result == $past(a_q)));
  p_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP && !b_zero && ovf) |=> (out_valid && result == (func_q[1] ? '0 : MIN_NEG)));
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(func_q));
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_func = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        busy, out_valid;
  logic [31:0] result;
  int          tests = 0, fails = 0;

  always #10 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_a(in_a), .in_b(in_b), .busy(busy),
    .out_valid(out_valid), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int f, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] x, y, p;
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    case (f)
      0: begin x = {32'b0, a}; y = {32'b0, b}; p = x * y; return p[31:0]; end
      1: begin x = {{32{a[31]}}, a}; y = {{32{b[31]}}, b}; p = x * y; return p[63:32]; end
      2: begin x = {{32{a[31]}}, a}; y = {32'b0, b}; p = x * y; return p[63:32]; end
      3: begin x = {32'b0, a}; y = {32'b0, b}; p = x * y; return p[63:32]; end
      4: if (b == 0) return 32'hFFFFFFFF;
         else if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'h80000000;
         else return 32'(sa / sb);
      5: return (b == 0) ? 32'hFFFFFFFF : a / b;
      6: if (b == 0) return a;
         else if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'h0;
         else return 32'(sa % sb);
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic string tag_of(input int f, input logic [31:0] a, input logic [31:0] b);
    if (f == 0) return "R2";
    if (f < 4) return "R3";
    if (b == 0) return (f < 6) ? "R4" : "R5";
    if ((f == 4 || f == 6) && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R6";
    return "R7";
  endfunction

  // request, then compare busy/out_valid each cycle against the expected schedule
  task automatic run_op(input int f, input logic [31:0] a, input logic [31:0] b, input bit intrude);
    logic [31:0] exp;
    int lat;
    exp = model(f, a, b);
    lat = (f < 4 || b == 0 || ((f == 4 || f == 6) && a == 32'h80000000 && b == 32'hFFFFFFFF)) ? 1 : 34;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready idle", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_func = 3'(f); in_a = a; in_b = b;
    for (int j = 0; j <= lat; j++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (intrude && j == 3) begin
        chk(in_ready == 1'b0, "R1 ready busy", 32'(in_ready), 32'd0);
        in_valid = 1'b1; in_func = 3'd0; in_a = 32'd3; in_b = 32'd3;
      end
      chk(busy == (j < lat), "R8 busy", 32'(busy), 32'(j < lat));
      chk(out_valid == (j == lat), "R8 out_valid", 32'(out_valid), 32'(j == lat));
    end
    chk(result == exp, tag_of(f, a, b), result, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 pulse", 32'(out_valid), 32'd0);
    chk(result == exp, "R9 hold", result, exp);
    chk(busy == 1'b0, "R1 no late start", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", 200000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] vals [5];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFFFFFF;
    vals[3] = 32'h80000000; vals[4] = 32'h7FFFFFFF;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R10 flags",
        {29'b0, busy, out_valid, in_ready}, 32'd1);
    chk(result == 32'h0, "R10 result", result, 32'h0);
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 5; i++)
        for (int k = 0; k < 5; k++)
          run_op(f, vals[i], vals[k], 1'b0);
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 12; r++)
        run_op(f, $urandom, (r < 4) ? ($urandom % 64) : $urandom, 1'b0);
    run_op(5, 32'd100, 32'd7, 1'b1);   // R1: request during division ignored
    run_op(6, 32'hFFFFFF9C, 32'd7, 1'b1);
    run_op(4, 32'hFFFFFFF9, 32'd2, 1'b0);  // R7: -7/2 = -3
    run_op(6, 32'hFFFFFFF9, 32'd2, 1'b0);  // R7: -7%2 = -1
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule